// File: doc/BRIEF.md
# Private-Format Frame Receive Classifier

This block watches the header bytes of each received frame while they stream in. It settles what happens to the frame before any payload byte has to be released. There are four outcomes: hand the frame to the local host, pass it to the relay queue for the next hop, take it as a schedule, or throw it away. The decision uses three 32-bit values: the node's own address, the all-ones broadcast address and the address of the node's configured parent. Each frame yields exactly one decision, together with the address and flow fields extracted from its header.

Frames arrive one byte per cycle whenever `rx_valid` is high. The first byte of a frame carries `rx_sof` and the last carries `rx_eof`. The positions the block relies on are as follows:

- Byte 0 is the format marker and must be 0xFF.
- Byte 1 is the type. 0x08 is a schedule and 0x0C is data.
- Byte 2 is a duration field that is not examined.

A schedule header is 8 bytes long and carries the sender node ID in bytes 3..6. A data header is 32 bytes long and lays out its fields like this:

- byte 3: flow ID
- bytes 4..7: next hop
- bytes 8..11: end destination
- bytes 12..15: original source
- bytes 16..21: unused by the block
- bytes 22..31: a zero-filled reserved area

All multi-byte fields are big-endian.

Top module: `rxc_frame_classifier`

## Requirements
- R1: A frame whose byte 0 is not 0xFF gets decision code 0 (drop) with no error flag. The decision is issued one cycle after byte 1, or one cycle after the frame's only byte.
- R2: A frame with a good marker and a type byte other than 0x08 or 0x0C gets code 0 (drop) with no error, one cycle after byte 1.
- R3: A schedule (type 0x08) whose sender field (bytes 3..6) equals `parent_addr` gets code 3 (schedule), and the sender is presented on `fld_sender`.
- R4: A schedule whose sender field differs from `parent_addr` gets code 0 (drop).
- R5: A data frame (type 0x0C) whose end destination (bytes 8..11) equals `own_addr` gets code 1 (host).
- R6: A data frame whose next hop (bytes 4..7) and end destination both equal 0xFFFFFFFF gets code 1 (host).
- R7: A data frame whose next hop equals `own_addr` and whose end destination does not gets code 2 (relay).
- R8: Every other complete data frame gets code 0 (drop) with no error. This includes a broadcast destination paired with a non-broadcast next hop that is not this node.
- R9: A frame that ends before its header is complete gets code 0 with `dec_err` high. A new `rx_sof` while a header is still incomplete also ends the old frame this way, one cycle after that start byte, and the start byte begins the next frame. A single-byte frame that arrives while an earlier header is incomplete is discarded, and only the earlier frame is reported.
- R10: A complete header is decided exactly one cycle after its last header byte: byte 7 for a schedule, byte 31 for data. This holds even when that byte also carries `rx_eof`. Each frame produces exactly one decision, and `dec_valid` is high for one cycle per decision.
- R11: When the code is 1 or 2, `fld_next_hop`, `fld_dest`, `fld_src` and `fld_flow` hold the frame's header fields in big-endian order.
- R12: Cycles with `rx_valid` low are ignored, so idle gaps between bytes do not change any decision or field.
- R13: Bytes that arrive outside a frame header produce no decision. This covers bytes without a preceding `rx_sof` and payload bytes after the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A byte is present on `rx_byte` this cycle |
| rx_sof | input | 1 | Current byte is the first of a frame |
| rx_eof | input | 1 | Current byte is the last of a frame |
| rx_byte | input | 8 | Received byte |
| own_addr | input | 32 | This node's address |
| parent_addr | input | 32 | Configured parent node ID |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_code | output | 2 | 0 drop, 1 host, 2 relay, 3 schedule |
| dec_err | output | 1 | Frame ended before its header was complete |
| fld_flow | output | 8 | Flow ID of the data header |
| fld_next_hop | output | 32 | Next-hop address |
| fld_dest | output | 32 | End-destination address |
| fld_src | output | 32 | Original source address |
| fld_sender | output | 32 | Schedule sender node ID |

## Verification
The hardest situations to reach from the ports are the ones where frame boundaries fall in awkward places relative to the header:

- a fresh start byte that cuts into a header still in progress;
- a frame whose end marker lands one byte short of the header length;
- a frame whose end marker lands exactly on the last header byte.

The stimulus reaches these cases by driving deliberately aborted headers. It then starts a full frame straight after, and sends frames of 31, 32, 7 and 8 bytes. Every decision is checked against the cycle it is due in. Idle gaps between bytes and stray bytes with no start marker show that nothing outside a header is ever decided.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int ADDR_W          = 32;
    localparam int ADDR_BYTES      = ADDR_W / 8;
    localparam int SCHED_HDR_BYTES = 8;
    localparam int DATA_HDR_BYTES  = 32;
    localparam int POS_W           = $clog2(DATA_HDR_BYTES);

    localparam logic [7:0] MARK_BYTE  = 8'hFF;
    localparam logic [7:0] TYPE_SCHED = 8'h08;
    localparam logic [7:0] TYPE_DATA  = 8'h0C;

    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

    localparam int TYPE_POS = 1;
    localparam int FLOW_POS = 3;

    // Address-sized capture slots
    localparam int NUM_SLOTS   = 4;
    localparam int SLOT_NEXT   = 0;
    localparam int SLOT_DEST   = 1;
    localparam int SLOT_SRC    = 2;
    localparam int SLOT_SENDER = 3;

    typedef enum logic [1:0] {
        DEC_DROP  = 2'd0,
        DEC_HOST  = 2'd1,
        DEC_RELAY = 2'd2,
        DEC_SCHED = 2'd3
    } dec_code_e;

    typedef enum logic [2:0] {
        EV_FOREIGN = 3'd0,
        EV_BADTYPE = 3'd1,
        EV_TRUNC   = 3'd2,
        EV_SCHED   = 3'd3,
        EV_DATA    = 3'd4
    } ev_kind_e;

    typedef struct packed {
        logic [7:0]        flow;
        logic [ADDR_W-1:0] next_hop;
        logic [ADDR_W-1:0] dest;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] sender;
    } hdr_fields_t;

    function automatic int slot_base(input int slot);
        case (slot)
            SLOT_NEXT:   return 4;
            SLOT_DEST:   return 8;
            SLOT_SRC:    return 12;
            default:     return 3;
        endcase
    endfunction

    function automatic logic [POS_W-1:0] hdr_last(input logic is_sched);
        return is_sched ? POS_W'(SCHED_HDR_BYTES - 1) : POS_W'(DATA_HDR_BYTES - 1);
    endfunction

endpackage

// File: rtl/rxc_hdr_tracker.sv
module rxc_hdr_tracker
    import rxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_byte,
    output logic             cap_en,
    output logic [POS_W-1:0] cap_pos,
    output logic             ev_valid,
    output ev_kind_e         ev_kind
);

    logic             active;
    logic [POS_W-1:0] idx;
    logic             marker_ok;
    logic             is_sched;
    logic [POS_W-1:0] last_pos;

    assign last_pos = hdr_last(is_sched);
    assign cap_en   = rx_valid && (rx_sof || active);
    assign cap_pos  = rx_sof ? '0 : idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            idx       <= '0;
            marker_ok <= 1'b0;
            is_sched  <= 1'b0;
            ev_valid  <= 1'b0;
            ev_kind   <= EV_FOREIGN;
        end else begin
            ev_valid <= 1'b0;
            if (rx_valid) begin
                if (rx_sof) begin
                    marker_ok <= (rx_byte == MARK_BYTE);
                    idx       <= POS_W'(1);
                    if (active) begin
                        // unfinished header cut off by a new start
                        ev_valid <= 1'b1;
                        ev_kind  <= EV_TRUNC;
                        active   <= !rx_eof;
                    end else if (rx_eof) begin
                        ev_valid <= 1'b1;
                        ev_kind  <= (rx_byte == MARK_BYTE) ? EV_TRUNC : EV_FOREIGN;
                        active   <= 1'b0;
                    end else begin
                        active <= 1'b1;
                    end
                end else if (active) begin
                    idx <= idx + POS_W'(1);
                    if (idx == POS_W'(TYPE_POS)) begin
                        if (!marker_ok) begin
                            ev_valid <= 1'b1;
                            ev_kind  <= EV_FOREIGN;
                            active   <= 1'b0;
                        end else if (rx_byte == TYPE_SCHED || rx_byte == TYPE_DATA) begin
                            is_sched <= (rx_byte == TYPE_SCHED);
                            if (rx_eof) begin
                                ev_valid <= 1'b1;
                                ev_kind  <= EV_TRUNC;
                                active   <= 1'b0;
                            end
                        end else begin
                            ev_valid <= 1'b1;
                            ev_kind  <= EV_BADTYPE;
                            active   <= 1'b0;
                        end
                    end else if (idx == last_pos) begin
                        ev_valid <= 1'b1;
                        ev_kind  <= is_sched ? EV_SCHED : EV_DATA;
                        active   <= 1'b0;
                    end else if (rx_eof) begin
                        ev_valid <= 1'b1;
                        ev_kind  <= EV_TRUNC;
                        active   <= 1'b0;
                    end
                end
            end
        end
    end

    // A bad marker is reported right after the type byte
    assert_foreign_at_type_R1: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_sof && active && idx == POS_W'(TYPE_POS) && !marker_ok)
        |=> (ev_valid && ev_kind == EV_FOREIGN));

    // The final header byte always yields a verdict on the next cycle
    assert_hdr_done_latency_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_sof && active && idx != POS_W'(TYPE_POS) && idx == last_pos)
        |=> (ev_valid && (ev_kind == EV_SCHED || ev_kind == EV_DATA)));

    // Bytes outside a header never produce a verdict
    assert_stray_ignored_R13: assert property (@(posedge clk) disable iff (rst)
        (!active && !(rx_valid && rx_sof)) |=> !ev_valid);

endmodule

// File: rtl/rxc_field_capture.sv
module rxc_field_capture
    import rxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [POS_W-1:0] cap_pos,
    input  logic [7:0]       rx_byte,
    output hdr_fields_t      fields
);

    logic [ADDR_W-1:0] slot_q [NUM_SLOTS];
    logic [7:0]        flow_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [POS_W:0] LO = (POS_W+1)'(slot_base(s));
        localparam logic [POS_W:0] HI = (POS_W+1)'(slot_base(s) + ADDR_BYTES);
        logic in_range;
        assign in_range = ({1'b0, cap_pos} >= LO) && ({1'b0, cap_pos} < HI);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[s] <= '0;
            end else if (cap_en && in_range) begin
                slot_q[s] <= {slot_q[s][ADDR_W-9:0], rx_byte};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flow_q <= '0;
        end else if (cap_en && cap_pos == POS_W'(FLOW_POS)) begin
            flow_q <= rx_byte;
        end
    end

    assign fields.flow     = flow_q;
    assign fields.next_hop = slot_q[SLOT_NEXT];
    assign fields.dest     = slot_q[SLOT_DEST];
    assign fields.src      = slot_q[SLOT_SRC];
    assign fields.sender   = slot_q[SLOT_SENDER];

endmodule

// File: rtl/rxc_rules.sv
module rxc_rules
    import rxc_pkg::*;
(
    input  ev_kind_e          ev_kind,
    input  logic [ADDR_W-1:0] next_hop,
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] sender,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] parent_addr,
    output dec_code_e         code,
    output logic              err
);

    logic dest_mine, next_mine, all_bcast;

    assign dest_mine = (dest == own_addr);
    assign next_mine = (next_hop == own_addr);
    assign all_bcast = (next_hop == BCAST_ADDR) && (dest == BCAST_ADDR);

    always_comb begin
        code = DEC_DROP;
        err  = 1'b0;
        unique case (ev_kind)
            EV_SCHED: code = (sender == parent_addr) ? DEC_SCHED : DEC_DROP;
            EV_DATA: begin
                if (dest_mine || all_bcast) code = DEC_HOST;
                else if (next_mine)         code = DEC_RELAY;
                else                        code = DEC_DROP;
            end
            EV_TRUNC: err = 1'b1;
            default:  code = DEC_DROP;
        endcase
    end

endmodule

// File: rtl/rxc_frame_classifier.sv
module rxc_frame_classifier
    import rxc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_byte,
    input  logic [31:0] own_addr,
    input  logic [31:0] parent_addr,
    output logic        dec_valid,
    output logic [1:0]  dec_code,
    output logic        dec_err,
    output logic [7:0]  fld_flow,
    output logic [31:0] fld_next_hop,
    output logic [31:0] fld_dest,
    output logic [31:0] fld_src,
    output logic [31:0] fld_sender
);

    logic             cap_en;
    logic [POS_W-1:0] cap_pos;
    logic             ev_valid;
    ev_kind_e         ev_kind;
    hdr_fields_t      fields;
    dec_code_e        code;
    logic             err;

    rxc_hdr_tracker u_tracker (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .rx_byte  (rx_byte),
        .cap_en   (cap_en),
        .cap_pos  (cap_pos),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind)
    );

    rxc_field_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_pos (cap_pos),
        .rx_byte (rx_byte),
        .fields  (fields)
    );

    rxc_rules u_rules (
        .ev_kind     (ev_kind),
        .next_hop    (fields.next_hop),
        .dest        (fields.dest),
        .sender      (fields.sender),
        .own_addr    (own_addr),
        .parent_addr (parent_addr),
        .code        (code),
        .err         (err)
    );

    assign dec_valid    = ev_valid;
    assign dec_code     = code;
    assign dec_err      = ev_valid && err;
    assign fld_flow     = fields.flow;
    assign fld_next_hop = fields.next_hop;
    assign fld_dest     = fields.dest;
    assign fld_src      = fields.src;
    assign fld_sender   = fields.sender;

    assert_sched_from_parent_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_code == DEC_SCHED) |-> (fld_sender == parent_addr));

    assert_host_addressing_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_code == DEC_HOST) |->
        (fld_dest == own_addr || (fld_dest == BCAST_ADDR && fld_next_hop == BCAST_ADDR)));

    assert_relay_addressing_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_code == DEC_RELAY) |->
        (fld_next_hop == own_addr && fld_dest != own_addr));

    assert_trunc_is_drop_R9: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (dec_valid && dec_code == DEC_DROP));

endmodule

// File: tb/rxc_frame_classifier_tb.sv
module rxc_frame_classifier_tb;

    localparam logic [31:0] OWN    = 32'h0A00_0005;
    localparam logic [31:0] PARENT = 32'h0A00_0001;
    localparam logic [31:0] OTHER  = 32'h0A00_0077;
    localparam logic [31:0] BC     = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        dec_valid, dec_err;
    logic [1:0]  dec_code;
    logic [7:0]  fld_flow;
    logic [31:0] fld_next_hop, fld_dest, fld_src, fld_sender;

    always #2 clk = ~clk;

    rxc_frame_classifier u_dut (
        .clk (clk), .rst (rst),
        .rx_valid (rx_valid), .rx_sof (rx_sof), .rx_eof (rx_eof), .rx_byte (rx_byte),
        .own_addr (OWN), .parent_addr (PARENT),
        .dec_valid (dec_valid), .dec_code (dec_code), .dec_err (dec_err),
        .fld_flow (fld_flow), .fld_next_hop (fld_next_hop), .fld_dest (fld_dest),
        .fld_src (fld_src), .fld_sender (fld_sender)
    );

    typedef struct {
        logic [1:0]  code;
        logic        err;
        bit          cmp_fields;
        logic [7:0]  flow;
        logic [31:0] next_hop, dest, src, sender;
        int          cyc;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    logic [7:0]  fr [0:63];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          abort_pending = 0;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R13", "unexpected decision", {30'd0, dec_code}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(dec_code == e.code, e.req, "code", {30'd0, dec_code}, {30'd0, e.code});
                chk(dec_err == e.err, e.req, "err", {31'd0, dec_err}, {31'd0, e.err});
                chk(cyc == e.cyc, "R10", "decision cycle", cyc, e.cyc);
                if (e.cmp_fields) begin
                    if (e.code == 2'd3) begin
                        chk(fld_sender == e.sender, e.req, "sender", fld_sender, e.sender);
                    end else begin
                        chk(fld_next_hop == e.next_hop, "R11", "next hop", fld_next_hop, e.next_hop);
                        chk(fld_dest == e.dest, "R11", "dest", fld_dest, e.dest);
                        chk(fld_src == e.src, "R11", "src", fld_src, e.src);
                        chk(fld_flow == e.flow, "R11", "flow", {24'd0, fld_flow}, {24'd0, e.flow});
                    end
                end
            end
        end
    end

    task automatic put32(input int at, input logic [31:0] v);
        for (int k = 0; k < 4; k++) fr[at+k] = v[31-8*k -: 8];
    endtask

    task automatic build_data(input logic [31:0] nh, input logic [31:0] ds,
                              input logic [31:0] sr, input logic [7:0] fl);
        for (int i = 0; i < 64; i++) fr[i] = 8'(i * 7 + 1);
        fr[0] = 8'hFF; fr[1] = 8'h0C; fr[2] = 8'h00; fr[3] = fl;
        put32(4, nh); put32(8, ds); put32(12, sr);
        for (int i = 22; i < 32; i++) fr[i] = 8'h00;
    endtask

    task automatic build_sched(input logic [31:0] snd);
        for (int i = 0; i < 64; i++) fr[i] = 8'(i * 5 + 3);
        fr[0] = 8'hFF; fr[1] = 8'h08; fr[2] = 8'h00;
        put32(3, snd); fr[7] = 8'h02;
    endtask

    function automatic logic [31:0] get32(input int at);
        return {fr[at], fr[at+1], fr[at+2], fr[at+3]};
    endfunction

    // Expected outcome from the requirements
    task automatic model(input int len, input string req, output exp_t e, output int di);
        int hl;
        e.code = 2'd0; e.err = 1'b0; e.cmp_fields = 0; e.req = req; e.cyc = 0;
        e.flow = fr[3]; e.next_hop = get32(4); e.dest = get32(8);
        e.src = get32(12); e.sender = get32(3);
        if (len == 1) begin
            di = 0; e.err = (fr[0] == 8'hFF);
        end else if (fr[0] != 8'hFF || (fr[1] != 8'h08 && fr[1] != 8'h0C)) begin
            di = 1;
        end else begin
            hl = (fr[1] == 8'h08) ? 8 : 32;
            if (len < hl) begin
                di = len - 1; e.err = 1'b1;
            end else begin
                di = hl - 1;
                if (fr[1] == 8'h08) begin
                    if (e.sender == PARENT) begin e.code = 2'd3; e.cmp_fields = 1; end
                end else if (e.dest == OWN || (e.dest == BC && e.next_hop == BC)) begin
                    e.code = 2'd1; e.cmp_fields = 1;
                end else if (e.next_hop == OWN) begin
                    e.code = 2'd2; e.cmp_fields = 1;
                end
            end
        end
    endtask

    task automatic send(input int len, input int gap, input string req);
        exp_t e;
        int di;
        model(len, req, e, di);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_byte = fr[i];
            if (i == 0 && abort_pending) begin
                exp_t t;
                t = '{code: 2'd0, err: 1'b1, cmp_fields: 0, flow: 8'd0, next_hop: 32'd0,
                      dest: 32'd0, src: 32'd0, sender: 32'd0, cyc: cyc + 1, req: "R9"};
                exp_q.push_back(t);
                abort_pending = 0;
            end
            if (i == di) begin
                e.cyc = cyc + 1;
                exp_q.push_back(e);
            end
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
                rx_valid = 1'b0; rx_byte = 8'hA5;
            end
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0; rx_byte = fr[i];
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0;
        abort_pending = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(dec_valid == 1'b0, "R10", "reset dec_valid", {31'd0, dec_valid}, 32'd0);
        chk(fld_dest == 32'd0, "R11", "reset dest", fld_dest, 32'd0);

        build_data(OTHER, OWN, 32'h0A00_0009, 8'h21);  send(40, 0, "R5");
        build_data(BC, BC, 32'h0A00_0003, 8'h22);      send(36, 0, "R6");
        build_data(OWN, OTHER, 32'h0A00_0004, 8'h23);  send(32, 0, "R7");
        build_data(OWN, BC, 32'h0A00_0004, 8'h24);     send(33, 0, "R7");
        build_data(OTHER, OTHER, 32'h0A00_0004, 8'h25); send(40, 0, "R8");
        build_data(OTHER, BC, 32'h0A00_0004, 8'h26);   send(40, 0, "R8");
        build_sched(PARENT);                           send(20, 0, "R3");
        build_sched(OTHER);                            send(20, 0, "R4");
        build_data(OTHER, OWN, 32'h1, 8'h01); fr[0] = 8'hFE; send(40, 0, "R1");
        fr[0] = 8'h00;                                 send(1, 0, "R1");
        build_data(OTHER, OWN, 32'h1, 8'h01); fr[1] = 8'h0A; send(40, 0, "R2");
        build_data(OTHER, OWN, 32'h1, 8'h01);          send(31, 0, "R9");
        build_sched(PARENT);                           send(7, 0, "R9");
        build_sched(PARENT);                           send(8, 0, "R10");
        build_data(OTHER, OWN, 32'h1, 8'h01);          send(2, 0, "R9");
        fr[0] = 8'hFF;                                 send(1, 0, "R9");
        build_data(OWN, 32'h0B00_0001, 32'hC0A8_0102, 8'h5A); send(34, 2, "R12");
        build_sched(PARENT);                           send(10, 3, "R12");

        // stray bytes without a start marker
        build_data(OTHER, OWN, 32'h1, 8'h01);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 5); rx_byte = fr[i];
        end
        @(posedge clk); #1; rx_valid = 1'b0; rx_eof = 1'b0;
        idle(4);

        // header cut by a new start, then a complete frame
        build_data(OTHER, OWN, 32'h1, 8'h01); send_partial(12);
        build_data(BC, BC, 32'h7, 8'h33);     send(40, 0, "R9");
        build_sched(OTHER);                   send_partial(5);
        build_sched(PARENT);                  send(9, 0, "R9");

        idle(8);
        chk(exp_q.size() == 0, "R10", "decisions outstanding", exp_q.size(), 32'd0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule